// File: doc/BRIEF.md
# Lane Mask Divergence Controller

This block keeps the per-lane activity state of a wavefront while a data-parallel program steps through an if/else. It holds three lane-wide registers: the execute mask (which lanes currently do work), the condition mask (the result of the last per-lane comparison) and a holding register that parks the execute mask while the two arms of the conditional run.

An external sequencer issues one mask command per cycle. A compare fills the condition mask. A save parks the execute mask. An "if" narrows the execute mask to the lanes whose condition is true. An "else" flips to the lanes that were parked but are not active now. A restore brings the parked mask back. Two combinational flags tell the sequencer when a whole code region can be skipped: one when no condition bit is set, and one when no lane is active.

The operands of the compare are supplied as packed lane vectors, and each lane compares its own pair. Instruction fetch, the program counter and the arithmetic datapath stay outside the block.

Top module: `lmask_divergence`

## Requirements
- R1: While reset (active-low `rstN`) is asserted and right after it is released, `execMask` is all ones and `vccMask` and `savedMask` are all zeros.
- R2: A valid command with code 1 (compare) sets each lane `i` of `vccMask` to one exactly when that lane is set in `execMask` and its operand A field (bits `i*OPW` upward) is greater than its operand B field as an unsigned number. Lanes that are inactive get zero. `execMask` and `savedMask` do not change.
- R3: A valid command with code 2 (save) copies `execMask` into `savedMask` and leaves `execMask` and `vccMask` unchanged.
- R4: A valid command with code 3 ("if") sets `execMask` to `execMask & vccMask`.
- R5: A valid command with code 4 ("else") sets `execMask` to `savedMask & ~execMask`.
- R6: A valid command with code 5 (restore) sets `execMask` to `savedMask`.
- R7: `skipIf` is high exactly when `vccMask` is all zeros. `skipElse` is high exactly when `execMask` is all zeros. Both follow the registers within the same cycle.
- R8: While `cmdValid` is low, or when the code is 0, 6 or 7, none of the three registers changes.
- R9: Each command takes effect at the rising edge on which it is presented, so back-to-back commands in consecutive cycles each see the result of the command before them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdOp | input | 3 | Command code: 0 none, 1 compare, 2 save, 3 if, 4 else, 5 restore |
| opA | input | LANES*OPW | Packed per-lane first compare operand |
| opB | input | LANES*OPW | Packed per-lane second compare operand |
| execMask | output | LANES | Active-lane mask |
| vccMask | output | LANES | Per-lane condition mask |
| savedMask | output | LANES | Parked execute mask |
| skipIf | output | 1 | No condition bit set; the "if" body may be skipped |
| skipElse | output | 1 | No lane active; the "else" body may be skipped |

## Verification
The bench builds the block with 8 lanes and 4-bit operands. With these values, masks where every lane passes, every lane fails, or no lane is active come up in only a few commands. Each lane's comparison can be set by hand in a single hex nibble. This makes it practical to drive both skip flags high, run a compare with the execute mask empty, and check that an "else" after an "if" in which every lane passed leaves no lane active.

// File: rtl/lmask_pkg.sv
package lmask_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_CMPGT    = 3'd1,
    OP_SAVE     = 3'd2,
    OP_IFAND    = 3'd3,
    OP_ELSEANDN = 3'd4,
    OP_RESTORE  = 3'd5
  } maskOp_e;

  typedef struct packed {
    logic cmpEn;
    logic saveEn;
    logic ifEn;
    logic elseEn;
    logic restoreEn;
  } maskStrobe_t;

endpackage

// File: rtl/lmask_lanecmp.sv
module lmask_lanecmp #(
  parameter int LANES = 64,
  parameter int OPW   = 16
) (
  input  logic [LANES*OPW-1:0] opA,
  input  logic [LANES*OPW-1:0] opB,
  output logic [LANES-1:0]     laneGt
);

  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [OPW-1:0] aField;
    logic [OPW-1:0] bField;
    assign aField    = opA[i*OPW +: OPW];
    assign bField    = opB[i*OPW +: OPW];
    assign laneGt[i] = (aField > bField);
  end

endmodule

// File: rtl/lmask_ctrl.sv
module lmask_ctrl
  import lmask_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  output maskStrobe_t strb
);

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      case (cmdOp)
        OP_CMPGT:    strb.cmpEn     = 1'b1;
        OP_SAVE:     strb.saveEn    = 1'b1;
        OP_IFAND:    strb.ifEn      = 1'b1;
        OP_ELSEANDN: strb.elseEn    = 1'b1;
        OP_RESTORE:  strb.restoreEn = 1'b1;
        default:     strb = '0;
      endcase
    end
  end

  // R8: idle or unused codes raise no strobe
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid || cmdOp == 3'd0 || cmdOp > 3'd5) |-> (strb == '0));

  // R9: at most one action per cycle
  assert_single_action_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/lmask_dp.sv
module lmask_dp
  import lmask_pkg::*;
#(
  parameter int LANES = 64,
  parameter int OPW   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  maskStrobe_t          strb,
  input  logic [LANES*OPW-1:0] opA,
  input  logic [LANES*OPW-1:0] opB,
  output logic [LANES-1:0]     execMask,
  output logic [LANES-1:0]     vccMask,
  output logic [LANES-1:0]     savedMask,
  output logic                 skipIf,
  output logic                 skipElse
);

  logic [LANES-1:0] execQ, vccQ, savedQ;
  logic [LANES-1:0] execNext, vccNext, savedNext;
  logic [LANES-1:0] gtLane;

  lmask_lanecmp #(.LANES(LANES), .OPW(OPW)) uCmp (
    .opA    (opA),
    .opB    (opB),
    .laneGt (gtLane)
  );

  always_comb begin
    execNext  = execQ;
    vccNext   = vccQ;
    savedNext = savedQ;
    if (strb.cmpEn)     vccNext   = gtLane & execQ;
    if (strb.saveEn)    savedNext = execQ;
    if (strb.ifEn)           execNext = execQ & vccQ;
    else if (strb.elseEn)    execNext = savedQ & ~execQ;
    else if (strb.restoreEn) execNext = savedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execQ  <= '1;
      vccQ   <= '0;
      savedQ <= '0;
    end else begin
      execQ  <= execNext;
      vccQ   <= vccNext;
      savedQ <= savedNext;
    end
  end

  assign execMask  = execQ;
  assign vccMask   = vccQ;
  assign savedMask = savedQ;
  assign skipIf    = ~|vccQ;
  assign skipElse  = ~|execQ;

  // R2: compare leaves no condition bit on an inactive lane, touches nothing else
  assert_cmp_masked_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmpEn |=> ((vccQ & ~execQ) == '0) && $stable(execQ) && $stable(savedQ));

  // R3: save parks the execute mask
  assert_save_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.saveEn |=> (savedQ == $past(execQ)) && $stable(execQ));

  // R4: "if" can only drop lanes
  assert_if_narrows_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.ifEn |=> ((execQ & ~$past(execQ)) == '0));

  // R5: "else" activates only lanes that were off
  assert_else_disjoint_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.elseEn |=> ((execQ & $past(execQ)) == '0));

  // R6: restore brings back the parked mask
  assert_restore_copy_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.restoreEn |=> (execQ == $past(savedQ)));

  // R8: no strobe, no change
  assert_hold_state_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(execQ) && $stable(vccQ) && $stable(savedQ));

endmodule

// File: rtl/lmask_divergence.sv
module lmask_divergence
  import lmask_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int OPW    = 16,
  localparam int OPBITS = LANES * OPW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [OPBITS-1:0] opA,
  input  logic [OPBITS-1:0] opB,
  output logic [LANES-1:0]  execMask,
  output logic [LANES-1:0]  vccMask,
  output logic [LANES-1:0]  savedMask,
  output logic              skipIf,
  output logic              skipElse
);

  maskStrobe_t strb;

  lmask_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .strb     (strb)
  );

  lmask_dp #(.LANES(LANES), .OPW(OPW)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .execMask  (execMask),
    .vccMask   (vccMask),
    .savedMask (savedMask),
    .skipIf    (skipIf),
    .skipElse  (skipElse)
  );

endmodule

// File: tb/lmask_divergence_test.sv
`timescale 1ns/1ps
module lmask_divergence_test;

  localparam int L = 8;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [L*W-1:0] opA = '0;
  logic [L*W-1:0] opB = '0;
  logic [L-1:0] execMask, vccMask, savedMask;
  logic skipIf, skipElse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [L-1:0] ex;
    logic [L-1:0] vc;
    logic [L-1:0] sv;
    logic sI;
    logic sE;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [L-1:0] mE = '1, mV = '0, mS = '0;

  always #4 clk = ~clk;

  lmask_divergence #(.LANES(L), .OPW(W)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .opA(opA), .opB(opB), .execMask(execMask), .vccMask(vccMask),
    .savedMask(savedMask), .skipIf(skipIf), .skipElse(skipElse)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [L-1:0] act, input logic [L-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // driver: present a command and queue the state expected after the edge
  task automatic issue(input logic v, input logic [2:0] op,
                       input logic [L*W-1:0] a, input logic [L*W-1:0] b,
                       input string tag);
    expItem_t it;
    @(negedge clk);
    cmdValid = v; cmdOp = op; opA = a; opB = b;
    if (v) begin
      case (op)
        3'd1: for (int i = 0; i < L; i++)
                mV[i] = mE[i] && (a[i*W +: W] > b[i*W +: W]);
        3'd2: mS = mE;
        3'd3: mE = mE & mV;
        3'd4: mE = mS & ~mE;
        3'd5: mE = mS;
        default: ;
      endcase
    end
    it.ex = mE; it.vc = mV; it.sv = mS;
    it.sI = (mV == '0); it.sE = (mE == '0); it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare after every edge that has an expected item
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(execMask == it.ex, it.tag, "execMask", execMask, it.ex);
        check(vccMask == it.vc, it.tag, "vccMask", vccMask, it.vc);
        check(savedMask == it.sv, it.tag, "savedMask", savedMask, it.sv);
        check(skipIf == it.sI, {it.tag, " R7"}, "skipIf", L'(skipIf), L'(it.sI));
        check(skipElse == it.sE, {it.tag, " R7"}, "skipElse", L'(skipElse), L'(it.sE));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(execMask == '1, "R1", "execMask in reset", execMask, '1);
    check(vccMask == '0, "R1", "vccMask in reset", vccMask, '0);
    check(savedMask == '0, "R1", "savedMask in reset", savedMask, '0);
    rstN = 1'b1;
    @(posedge clk); #2;
    check(execMask == '1, "R1", "execMask after reset", execMask, '1);
    check(savedMask == '0, "R1", "savedMask after reset", savedMask, '0);
    check(skipIf == 1'b1, "R1 R7", "skipIf after reset", L'(skipIf), 8'h01);

    // mixed condition: lanes 1,3,5,7 pass
    issue(1, 3'd1, 32'h81726354, 32'h44444444, "R2 mixed");
    issue(1, 3'd2, '0, '0, "R3 save");
    issue(1, 3'd3, '0, '0, "R4 R9 if");
    issue(1, 3'd1, 32'hFFFFFFFF, 32'h00000000, "R2 inactive lanes cleared");
    issue(1, 3'd4, '0, '0, "R5 R9 else");
    issue(1, 3'd5, '0, '0, "R6 restore");
    // ignored commands
    issue(1, 3'd0, 32'hFFFFFFFF, '0, "R8 code0");
    issue(1, 3'd6, 32'hFFFFFFFF, '0, "R8 code6");
    issue(1, 3'd7, '0, '0, "R8 code7");
    issue(0, 3'd3, '0, '0, "R8 invalid if");
    issue(0, 3'd1, 32'hFFFFFFFF, '0, "R8 invalid cmp");
    // all lanes fail
    issue(1, 3'd1, 32'h12345678, 32'h12345678, "R2 equal fails");
    issue(1, 3'd3, '0, '0, "R4 all fail");
    issue(1, 3'd1, 32'hFFFFFFFF, '0, "R2 no lane active");
    issue(1, 3'd5, '0, '0, "R6 restore full");
    // all lanes pass, else leaves nothing
    issue(1, 3'd1, 32'hFFFFFFFF, '0, "R2 all pass");
    issue(1, 3'd2, '0, '0, "R3 save full");
    issue(1, 3'd3, '0, '0, "R4 all pass");
    issue(1, 3'd4, '0, '0, "R5 empty else");
    issue(1, 3'd5, '0, '0, "R6 restore");
    // nested region
    issue(1, 3'd1, 32'h0000FFFF, 32'h00000000, "R2 low half");
    issue(1, 3'd2, '0, '0, "R3 outer save");
    issue(1, 3'd3, '0, '0, "R4 outer if");
    issue(1, 3'd1, 32'h0000A5A5, 32'h00005A5A, "R2 inner cmp");
    issue(1, 3'd3, '0, '0, "R4 inner if");
    issue(1, 3'd4, '0, '0, "R5 flip");
    issue(1, 3'd5, '0, '0, "R6 outer restore");
    issue(0, 3'd0, '0, '0, "R8 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule